// File: doc/BRIEF.md
# Latching/Registering Bus Driver Stage

This block carries a data word from an input bus to an output bus through one storage stage. A mode control picks how that stage behaves on each cycle. When the control is high the stage is transparent and the output follows the input. When it is low the stage acts as an edge-triggered register, loading the input on each rising edge of a separate strobe input. An active-low drive enable, shared by every bit, turns the output drivers off without touching the stored word.

The whole stage runs in one system-clock domain. Every system-clock edge samples the mode control, the strobe and the data. A strobe rising edge is found by comparing the current strobe sample with the one before it. The three-state output is modelled as a data vector plus a per-bit drive-enable vector, which the pad ring turns into real three-state buffers. A four-state machine, `mode_e`, records the previous sample:

- `ST_PASS_LO`: transparent, strobe low.
- `ST_PASS_HI`: transparent, strobe high.
- `ST_HOLD_LO`: holding, strobe low. A rising strobe edge is armed.
- `ST_HOLD_HI`: holding, strobe high.

Every sample moves the machine to the state named by the mode and strobe just sampled. Reset places it in `ST_HOLD_LO` or `ST_HOLD_HI` according to the strobe level. The word is loaded in two cases: when the sampled mode is transparent, or when the mode is low and a high strobe follows a `*_LO` state.

Top module: `bus_stage_driver`

## Requirements
- R1: When `drive_n` is 1, every bit of `dout_oe` is 0 in the same cycle. When `drive_n` is 0, every bit is 1.
- R2: If `xparent` is 1 at a system-clock edge, `dout` equals the `din` sampled at that edge from that edge on.
- R3: If `xparent` is 0 and `strobe` is 1 at an edge, and `strobe` was 0 at the previous edge, `dout` takes the `din` sampled at that edge.
- R4: With `xparent` at 0 and `strobe` held at 1, `dout` keeps its value while `din` changes.
- R5: With `xparent` at 0 and `strobe` held at 0, `dout` keeps its value while `din` changes.
- R6: A falling `strobe` (1 then 0) with `xparent` at 0 leaves `dout` unchanged.
- R7: A `strobe` rise seen while `xparent` is 1 acts only as transparency. If `xparent` then drops with `strobe` still high, nothing is captured.
- R8: `drive_n` never changes the stored word. Words are still stored while the drivers are off, and re-enabling shows the held word on `dout`.
- R9: A synchronous active-high `sys_rst` clears the stored word to 0. During reset the strobe is still sampled as the previous level.
- R10: When `xparent` falls with `strobe` low, `dout` keeps the word from the last transparent sample.
- R11: If `xparent` falls in the same sample in which `strobe` rises, that sample's `din` is captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; all inputs are sampled on its rising edge |
| sys_rst | input | 1 | Synchronous active-high reset |
| din | input | DATA_W | Input data word |
| xparent | input | 1 | Mode: 1 = transparent, 0 = strobe-edge register |
| strobe | input | 1 | Data strobe; a rising edge loads the word in register mode |
| drive_n | input | 1 | Active-low output drive enable, shared by all bits |
| dout | output | DATA_W | Stored/transparent word |
| dout_oe | output | DATA_W | Per-bit drive enable for the output pads |

## Verification
Directed sequences set transparent streams against strobe-held-high, strobe-held-low and falling-strobe holds. This separates a latch that leaks data from one that holds correctly. Separate sequences raise the strobe during transparency and then drop the mode, and drop the mode in the same sample as a strobe rise. These two show whether edge detection uses the sample before the mode change. Toggling the drive enable while words are captured shows that gating the pads never disturbs storage. A long random run against a behavioural model covers mixed orderings.

// File: rtl/bsd_pkg.sv
package bsd_pkg;

    // Previous-sample record: mode and strobe level
    typedef enum logic [1:0] {
        ST_PASS_LO = 2'd0,
        ST_PASS_HI = 2'd1,
        ST_HOLD_LO = 2'd2,
        ST_HOLD_HI = 2'd3
    } mode_e;

endpackage

// File: rtl/bsd_mode_fsm.sv
module bsd_mode_fsm
    import bsd_pkg::*;
(
    input  logic sys_clk,
    input  logic sys_rst,
    input  logic xparent,
    input  logic strobe,
    output logic load
);

    mode_e state_q;
    mode_e state_d;
    logic  prev_hi;

    // State register
    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            state_q <= strobe ? ST_HOLD_HI : ST_HOLD_LO;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and load decision
    always_comb begin
        unique case (state_q)
            ST_PASS_LO: prev_hi = 1'b0;
            ST_PASS_HI: prev_hi = 1'b1;
            ST_HOLD_LO: prev_hi = 1'b0;
            ST_HOLD_HI: prev_hi = 1'b1;
        endcase

        if (xparent) begin
            state_d = strobe ? ST_PASS_HI : ST_PASS_LO;
        end else begin
            state_d = strobe ? ST_HOLD_HI : ST_HOLD_LO;
        end

        load = xparent || (strobe && !prev_hi);
    end

endmodule

// File: rtl/bsd_store.sv
module bsd_store #(
    parameter int W = 18
) (
    input  logic         sys_clk,
    input  logic         sys_rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge sys_clk) begin
        if (sys_rst) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

endmodule

// File: rtl/bsd_out_gate.sv
module bsd_out_gate #(
    parameter int W = 18
) (
    input  logic         drive_n,
    input  logic [W-1:0] word,
    output logic [W-1:0] pad_d,
    output logic [W-1:0] pad_oe
);

    // One pad driver slice per bit, all sharing the enable
    for (genvar b = 0; b < W; b++) begin : g_bit
        assign pad_d[b]  = word[b];
        assign pad_oe[b] = ~drive_n;
    end

endmodule

// File: rtl/bus_stage_driver.sv
module bus_stage_driver #(
    parameter int DATA_W = 18
) (
    input  logic              sys_clk,
    input  logic              sys_rst,
    input  logic [DATA_W-1:0] din,
    input  logic              xparent,
    input  logic              strobe,
    input  logic              drive_n,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] dout_oe
);

    logic              load;
    logic [DATA_W-1:0] held;

    bsd_mode_fsm u_fsm (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .xparent (xparent),
        .strobe  (strobe),
        .load    (load)
    );

    bsd_store #(.W(DATA_W)) u_store (
        .sys_clk (sys_clk),
        .sys_rst (sys_rst),
        .load    (load),
        .d       (din),
        .q       (held)
    );

    bsd_out_gate #(.W(DATA_W)) u_gate (
        .drive_n (drive_n),
        .word    (held),
        .pad_d   (dout),
        .pad_oe  (dout_oe)
    );

endmodule

// File: rtl/bsd_chk.sv
module bsd_chk #(
    parameter int W = 18
) (
    input logic         sys_clk,
    input logic         sys_rst,
    input logic [W-1:0] din,
    input logic         xparent,
    input logic         strobe,
    input logic         drive_n,
    input logic [W-1:0] dout,
    input logic [W-1:0] dout_oe
);

    // R1
    oe_off_chk: assert property (@(posedge sys_clk) drive_n |-> dout_oe == '0);

    // R1
    oe_on_chk: assert property (@(posedge sys_clk) !drive_n |-> dout_oe == '1);

    // R2
    pass_follow_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        xparent |=> dout == $past(din));

    // R3
    edge_capture_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!xparent && strobe && !$past(strobe)) |=> dout == $past(din));

    // R4
    hold_chk: assert property (@(posedge sys_clk) disable iff (sys_rst)
        (!xparent && !(strobe && !$past(strobe))) |=> $stable(dout));

    // R9
    reset_clear_chk: assert property (@(posedge sys_clk)
        sys_rst |=> dout == '0);

endmodule

bind bus_stage_driver bsd_chk #(.W(DATA_W)) u_chk (
    .sys_clk (sys_clk),
    .sys_rst (sys_rst),
    .din     (din),
    .xparent (xparent),
    .strobe  (strobe),
    .drive_n (drive_n),
    .dout    (dout),
    .dout_oe (dout_oe)
);

// File: tb/sim_bus_stage_driver.sv
module sim_bus_stage_driver;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] din = '0;
    logic         le  = 1'b0;
    logic         stb = 1'b0;
    logic         oe_n = 1'b0;
    logic [W-1:0] dout;
    logic [W-1:0] dout_oe;

    int checks = 0;
    int failures = 0;

    logic [W-1:0] ref_q = '0;
    logic         ref_prev = 1'b0;

    always #10 clk = ~clk;

    bus_stage_driver #(.DATA_W(W)) u0 (
        .sys_clk (clk),
        .sys_rst (rst),
        .din     (din),
        .xparent (le),
        .strobe  (stb),
        .drive_n (oe_n),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    // Behavioural reference of the stored word
    always @(posedge clk) begin
        if (rst) ref_q <= '0;
        else if (le) ref_q <= din;
        else if (stb && !ref_prev) ref_q <= din;
        ref_prev <= stb;
    end

    task automatic check_val(input string tag, input logic [W-1:0] act,
                             input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one sample, then check after the next edge, away from it
    task automatic cyc(input logic [W-1:0] d, input logic l, input logic s,
                       input logic o, input string tag);
        din = d; le = l; stb = s; oe_n = o;
        @(posedge clk);
        @(negedge clk);
        check_val(tag, dout, ref_q);
        check_val("R1", dout_oe, {W{~oe_n}});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        din = 18'h2AAAA; stb = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R9", dout, 18'h0);
        rst = 1'b0;

        // R9: strobe was high during reset, stays high: no capture
        cyc(18'h11111, 1'b0, 1'b1, 1'b0, "R9");
        check_val("R9", dout, 18'h0);

        // R2 transparent stream
        cyc(18'h12345, 1'b1, 1'b0, 1'b0, "R2");
        check_val("R2", dout, 18'h12345);
        cyc(18'h3FFFF, 1'b1, 1'b0, 1'b0, "R2");
        cyc(18'h00F0F, 1'b1, 1'b0, 1'b0, "R2");
        check_val("R2", dout, 18'h00F0F);

        // R10 mode falls with strobe low; R5 strobe held low
        cyc(18'h15555, 1'b0, 1'b0, 1'b0, "R10");
        check_val("R10", dout, 18'h00F0F);
        cyc(18'h0AAAA, 1'b0, 1'b0, 1'b0, "R5");
        check_val("R5", dout, 18'h00F0F);

        // R3 rising edge capture; R4 held high; R6 falling
        cyc(18'h2C3C3, 1'b0, 1'b1, 1'b0, "R3");
        check_val("R3", dout, 18'h2C3C3);
        cyc(18'h01234, 1'b0, 1'b1, 1'b0, "R4");
        check_val("R4", dout, 18'h2C3C3);
        cyc(18'h3ABCD, 1'b0, 1'b0, 1'b0, "R6");
        check_val("R6", dout, 18'h2C3C3);

        // R7 strobe rises during transparency, then mode drops
        cyc(18'h00001, 1'b1, 1'b0, 1'b0, "R7");
        cyc(18'h0BEEF, 1'b1, 1'b1, 1'b0, "R7");
        cyc(18'h3DEAD, 1'b0, 1'b1, 1'b0, "R7");
        check_val("R7", dout, 18'h0BEEF);
        cyc(18'h1F00D, 1'b0, 1'b1, 1'b0, "R4");
        check_val("R4", dout, 18'h0BEEF);

        // R11 mode falls in the same sample as strobe rise
        cyc(18'h04444, 1'b1, 1'b0, 1'b0, "R11");
        cyc(18'h27777, 1'b0, 1'b1, 1'b0, "R11");
        check_val("R11", dout, 18'h27777);

        // R8 drivers off: storage unaffected, capture still works
        cyc(18'h10101, 1'b0, 1'b0, 1'b1, "R8");
        check_val("R1", dout_oe, 18'h0);
        check_val("R8", dout, 18'h27777);
        cyc(18'h20202, 1'b0, 1'b1, 1'b1, "R8");
        check_val("R8", dout, 18'h20202);
        cyc(18'h30303, 1'b0, 1'b1, 1'b0, "R8");
        check_val("R8", dout, 18'h20202);
        check_val("R1", dout_oe, 18'h3FFFF);

        // Mixed random orderings against the model
        for (int i = 0; i < 400; i++) begin
            cyc(W'($urandom), 1'($urandom_range(0, 3) == 0),
                1'($urandom), 1'($urandom_range(0, 4) == 0), "R3");
        end

        // R9 reset mid-run
        rst = 1'b1;
        cyc(18'h3FFFF, 1'b1, 1'b0, 1'b0, "R9");
        check_val("R9", dout, 18'h0);
        rst = 1'b0;

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule